// File: doc/BRIEF.md
# UDP/IPv4 Receive Header Parser

This block sits after Ethernet header removal in a receive path. It accepts a byte-enabled beat stream in which each packet starts with a 20-byte IPv4 header and an 8-byte UDP header. It takes those 28 bytes apart and presents one metadata record per packet. The bytes that follow are shifted down so that the first payload byte lands in lane 0 of the first output beat, and they leave as a packed beat stream. Byte 0 of a beat travels in bits 7:0, and multi-byte header fields are big-endian.

Every packet is screened on its first beat. The IPv4 header checksum must verify, and the destination address must belong to this node. A packet that fails either test is removed whole: no metadata record and no payload beat. Because the whole header sits inside the first beat, the verdict is known before any payload is released. No payload storage beyond a one-beat residue is needed.

Before anything is accepted, a configuration pulse loads the local IPv4 address and netmask. The input has no back-pressure, and both output channels are valid-only.

Top module: `udp_ipv4_rx_parser`

## Requirements
- R1: After reset, meta_valid and out_valid are low. Every packet whose first beat arrives before the first cfg_load is discarded whole.
- R2: A cfg_load pulse captures cfg_ip and cfg_mask. A packet is judged against the configuration held when its first beat (in_first high) is taken, so a load in that same cycle applies only to later packets.
- R3: For an accepted packet, meta_valid pulses one cycle after its first beat is taken. The record carries the following fields, taken from the byte positions given:
  - meta_src_ip: bytes 12-15.
  - meta_dscp: byte 1 bits 7:2.
  - meta_ecn: byte 1 bits 1:0.
  - meta_src_port: bytes 20-21.
  - meta_dst_port: bytes 22-23.
- R4: meta_len is the UDP length field (bytes 24-25) minus 8.
- R5: The header is valid when the following sum equals 0xFFFF: the ones'-complement sum of the ten big-endian 16-bit words in bytes 0-19, with carries folded back in. Any other sum discards the whole packet.
- R6: The UDP checksum in bytes 26-27 has no effect on acceptance or on any output.
- R7: A packet is accepted in either of two cases. In the first, its destination (bytes 16-19) equals the local address. In the second, it has the same masked prefix as the local address and all host bits set. Any other destination discards the whole packet.
- R8: Output lane j of payload beat k carries payload byte k*B+j, where B is the beat width in bytes, and payload byte 0 is stream byte 28.
- R9: Payload beat k appears one cycle after input beat k+1 is taken. If no input beat k+1 exists, it appears one cycle after the last input beat.
- R10: Every payload beat except the last has all out_keep bits set. The last beat sets exactly the low (P mod B) lanes, or all B lanes when P is a multiple of B, where P is the payload length. out_last is high on that beat only.
- R11: A packet with no payload produces its metadata record and no payload beat.
- R12: A discarded packet sent back-to-back between accepted packets leaves their records and beats unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load local addressing |
| cfg_ip | input | 32 | Local IPv4 address |
| cfg_mask | input | 32 | Local netmask |
| in_valid | input | 1 | Input beat present |
| in_first | input | 1 | Beat is the first of a packet |
| in_last | input | 1 | Beat is the last of a packet |
| in_data | input | BEAT_BYTES*8 | Input bytes, lane 0 in bits 7:0 |
| in_keep | input | BEAT_BYTES | Input byte enables |
| meta_valid | output | 1 | Metadata record present |
| meta_len | output | 16 | Payload length in bytes |
| meta_src_ip | output | 32 | Sender IPv4 address |
| meta_dscp | output | 6 | Differentiated services code |
| meta_ecn | output | 2 | Congestion notification bits |
| meta_src_port | output | 16 | UDP source port |
| meta_dst_port | output | 16 | UDP destination port |
| out_valid | output | 1 | Payload beat present |
| out_data | output | BEAT_BYTES*8 | Realigned payload bytes |
| out_keep | output | BEAT_BYTES | Payload byte enables |
| out_last | output | 1 | Final payload beat |

## Verification
The hardest situation to reach is the collision of two packets' events in one cycle. In that cycle, the residue flush of one packet, whose payload spills past its last input beat, coincides with the first beat of the next packet reloading the residue register. The stimulus reaches it by sending packets with no idle cycle between them. The payload lengths (4, 36, 100) are chosen so that each needs a flush beat, and a failing packet is placed in the middle of such a run. A configuration load issued in the exact cycle of a first beat covers the ordering rule for configuration.

// File: rtl/udp_rx_pkg.sv
`timescale 1ns/1ps
package udp_rx_pkg;

    localparam int HDR_BYTES  = 28;
    localparam int USED_BYTES = 26;
    localparam int IP_BYTES   = 20;

    typedef struct packed {
        logic [15:0] len;
        logic [31:0] src_ip;
        logic [5:0]  dscp;
        logic [1:0]  ecn;
        logic [15:0] src_port;
        logic [15:0] dst_port;
    } udp_meta_t;

    typedef struct packed {
        logic [31:0] ip;
        logic [31:0] mask;
    } local_cfg_t;

    function automatic logic [15:0] be_word(input logic [USED_BYTES*8-1:0] h, input int idx);
        return {h[idx*8 +: 8], h[idx*8+8 +: 8]};
    endfunction

    function automatic logic ip_sum_ok(input logic [IP_BYTES*8-1:0] h);
        logic [19:0] acc;
        logic [16:0] f1;
        logic [15:0] f2;
        acc = '0;
        for (int w = 0; w < IP_BYTES/2; w++)
            acc = acc + {4'd0, h[w*16 +: 8], h[w*16+8 +: 8]};
        f1 = {1'b0, acc[15:0]} + {13'd0, acc[19:16]};
        f2 = f1[15:0] + {15'd0, f1[16]};
        return f2 == 16'hFFFF;
    endfunction

    function automatic logic dst_is_local(input logic [31:0] dst, input local_cfg_t c);
        logic unicast, bcast;
        unicast = (dst == c.ip);
        bcast   = ((dst & c.mask) == (c.ip & c.mask)) && ((dst | c.mask) == 32'hFFFF_FFFF);
        return unicast || bcast;
    endfunction

endpackage

// File: rtl/udp_hdr_check.sv
`timescale 1ns/1ps
module udp_hdr_check
    import udp_rx_pkg::*;
(
    input  logic [USED_BYTES*8-1:0] hdr,
    input  local_cfg_t              cfg,
    output udp_meta_t               meta,
    output logic                    accept
);
    logic [31:0] dst_ip;
    logic        sum_good;
    logic        dst_good;

    always_comb begin
        dst_ip        = {be_word(hdr, 16), be_word(hdr, 18)};
        meta.src_ip   = {be_word(hdr, 12), be_word(hdr, 14)};
        meta.dscp     = hdr[15:10];
        meta.ecn      = hdr[9:8];
        meta.src_port = be_word(hdr, 20);
        meta.dst_port = be_word(hdr, 22);
        meta.len      = be_word(hdr, 24) - 16'd8;
        sum_good      = ip_sum_ok(hdr[IP_BYTES*8-1:0]);
        dst_good      = dst_is_local(dst_ip, cfg);
        accept        = sum_good && dst_good;
    end
endmodule

// File: rtl/udp_payload_align.sv
`timescale 1ns/1ps
module udp_payload_align #(
    parameter int BEAT_BYTES = 32,
    parameter int SKIP_BYTES = 28
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic                    first,
    input  logic                    last,
    input  logic [BEAT_BYTES*8-1:0] data,
    input  logic [BEAT_BYTES-1:0]   keep,
    output logic                    out_valid,
    output logic [BEAT_BYTES*8-1:0] out_data,
    output logic [BEAT_BYTES-1:0]   out_keep,
    output logic                    out_last
);
    localparam int RES = BEAT_BYTES - SKIP_BYTES;
    localparam int DW  = BEAT_BYTES * 8;

    logic [RES*8-1:0]        hold_data;
    logic [RES-1:0]          hold_keep;
    logic                    tail_pend;
    logic [RES*8-1:0]        up_data;
    logic [RES-1:0]          up_keep;
    logic [SKIP_BYTES*8-1:0] lo_data;
    logic [SKIP_BYTES-1:0]   lo_keep;
    logic                    up_any;

    assign up_data = data[DW-1 -: RES*8];
    assign up_keep = keep[BEAT_BYTES-1 -: RES];
    assign lo_data = data[SKIP_BYTES*8-1:0];
    assign lo_keep = keep[SKIP_BYTES-1:0];
    assign up_any  = |up_keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            out_keep  <= '0;
            hold_data <= '0;
            hold_keep <= '0;
            tail_pend <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (tail_pend) begin
                out_valid <= 1'b1;
                out_last  <= 1'b1;
                out_data  <= {{(SKIP_BYTES*8){1'b0}}, hold_data};
                out_keep  <= {{SKIP_BYTES{1'b0}}, hold_keep};
                tail_pend <= 1'b0;
            end
            if (take) begin
                hold_data <= up_data;
                hold_keep <= up_keep;
                tail_pend <= last && up_any;
                if (!first) begin
                    out_valid <= 1'b1;
                    out_last  <= last && !up_any;
                    out_data  <= {lo_data, hold_data};
                    out_keep  <= {lo_keep, hold_keep};
                end
            end
        end
    end
endmodule

// File: rtl/udp_ipv4_rx_parser.sv
`timescale 1ns/1ps
module udp_ipv4_rx_parser
    import udp_rx_pkg::*;
#(
    parameter int BEAT_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_load,
    input  logic [31:0]             cfg_ip,
    input  logic [31:0]             cfg_mask,
    input  logic                    in_valid,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic [BEAT_BYTES*8-1:0] in_data,
    input  logic [BEAT_BYTES-1:0]   in_keep,
    output logic                    meta_valid,
    output logic [15:0]             meta_len,
    output logic [31:0]             meta_src_ip,
    output logic [5:0]              meta_dscp,
    output logic [1:0]              meta_ecn,
    output logic [15:0]             meta_src_port,
    output logic [15:0]             meta_dst_port,
    output logic                    out_valid,
    output logic [BEAT_BYTES*8-1:0] out_data,
    output logic [BEAT_BYTES-1:0]   out_keep,
    output logic                    out_last
);
    local_cfg_t cfg_q;
    logic       cfg_ok;
    logic       pkt_pass;
    udp_meta_t  meta_now;
    udp_meta_t  meta_q;
    logic       hdr_accept;
    logic       accept_now;
    logic       beat_take;

    udp_hdr_check i_hdr (
        .hdr    (in_data[USED_BYTES*8-1:0]),
        .cfg    (cfg_q),
        .meta   (meta_now),
        .accept (hdr_accept)
    );

    assign accept_now = cfg_ok && hdr_accept;
    assign beat_take  = in_valid && (in_first ? accept_now : pkt_pass);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            cfg_ok     <= 1'b0;
            pkt_pass   <= 1'b0;
            meta_valid <= 1'b0;
            meta_q     <= '0;
        end else begin
            if (cfg_load) begin
                cfg_q.ip   <= cfg_ip;
                cfg_q.mask <= cfg_mask;
                cfg_ok     <= 1'b1;
            end
            meta_valid <= 1'b0;
            if (in_valid && in_first) begin
                pkt_pass <= accept_now;
                if (accept_now) begin
                    meta_valid <= 1'b1;
                    meta_q     <= meta_now;
                end
            end
        end
    end

    assign meta_len      = meta_q.len;
    assign meta_src_ip   = meta_q.src_ip;
    assign meta_dscp     = meta_q.dscp;
    assign meta_ecn      = meta_q.ecn;
    assign meta_src_port = meta_q.src_port;
    assign meta_dst_port = meta_q.dst_port;

    udp_payload_align #(
        .BEAT_BYTES (BEAT_BYTES),
        .SKIP_BYTES (HDR_BYTES)
    ) i_align (
        .clk       (clk),
        .rst       (rst),
        .take      (beat_take),
        .first     (in_first),
        .last      (in_last),
        .data      (in_data),
        .keep      (in_keep),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_keep  (out_keep),
        .out_last  (out_last)
    );
endmodule

// File: rtl/udp_rx_parser_chk.sv
`timescale 1ns/1ps
module udp_rx_parser_chk #(
    parameter int BEAT_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_first,
    input logic                  in_last,
    input logic                  meta_valid,
    input logic                  out_valid,
    input logic                  out_last,
    input logic [BEAT_BYTES-1:0] out_keep
);
    logic [BEAT_BYTES-1:0] keep_inc;
    assign keep_inc = out_keep + {{(BEAT_BYTES-1){1'b0}}, 1'b1};

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!meta_valid && !out_valid));

    // R3
    meta_follows_first_chk: assert property (@(posedge clk) disable iff (rst)
        meta_valid |-> $past(in_valid && in_first));

    // R9
    beat_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) || $past(in_valid && in_last, 2)));

    // R10
    last_has_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && out_keep[0]));

    // R10
    full_mid_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (&out_keep));

    // R10
    keep_packed_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((keep_inc & out_keep) == '0));
endmodule

bind udp_ipv4_rx_parser udp_rx_parser_chk #(.BEAT_BYTES(BEAT_BYTES)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_last    (in_last),
    .meta_valid (meta_valid),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .out_keep   (out_keep)
);

// File: tb/test_udp_ipv4_rx_parser.sv
`timescale 1ns/1ps
module test_udp_ipv4_rx_parser;
    localparam int B  = 32;
    localparam int DW = B * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [31:0]   cfg_ip = '0;
    logic [31:0]   cfg_mask = '0;
    logic          in_valid = 1'b0;
    logic          in_first = 1'b0;
    logic          in_last = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [B-1:0]  in_keep = '0;
    logic          meta_valid;
    logic [15:0]   meta_len;
    logic [31:0]   meta_src_ip;
    logic [5:0]    meta_dscp;
    logic [1:0]    meta_ecn;
    logic [15:0]   meta_src_port;
    logic [15:0]   meta_dst_port;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [B-1:0]  out_keep;
    logic          out_last;

    always #4 clk = ~clk;

    udp_ipv4_rx_parser #(.BEAT_BYTES(B)) i_udp_ipv4_rx_parser (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_ip(cfg_ip), .cfg_mask(cfg_mask),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_data(in_data), .in_keep(in_keep),
        .meta_valid(meta_valid), .meta_len(meta_len), .meta_src_ip(meta_src_ip),
        .meta_dscp(meta_dscp), .meta_ecn(meta_ecn), .meta_src_port(meta_src_port),
        .meta_dst_port(meta_dst_port), .out_valid(out_valid), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last)
    );

    typedef struct {
        int          cyc;
        logic [15:0] len;
        logic [71:0] rest;
    } exp_meta_t;

    typedef struct {
        int            cyc;
        logic [DW-1:0] data;
        logic [B-1:0]  keep;
        bit            last;
    } exp_beat_t;

    exp_meta_t  mq[$];
    string      mtag[$];
    exp_beat_t  pq[$];
    string      ptag[$];
    logic [7:0] pkt[$];
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    int         unexpected = 0;
    string      drop_tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic build(input logic [31:0] src, input logic [31:0] dst,
                         input logic [15:0] sp, input logic [15:0] dp,
                         input logic [5:0] dscp, input logic [1:0] ecn,
                         input int plen, input logic [15:0] ucs,
                         input bit corrupt, input int seed);
        int sum;
        logic [15:0] cs;
        int tot;
        tot = 28 + plen;
        pkt.delete();
        pkt.push_back(8'h45); pkt.push_back({dscp, ecn});
        pkt.push_back(tot[15:8]); pkt.push_back(tot[7:0]);
        pkt.push_back(seed[15:8]); pkt.push_back(seed[7:0]);
        pkt.push_back(8'h40); pkt.push_back(8'h00);
        pkt.push_back(8'd64); pkt.push_back(8'd17);
        pkt.push_back(8'h00); pkt.push_back(8'h00);
        for (int i = 3; i >= 0; i--) pkt.push_back(src[i*8 +: 8]);
        for (int i = 3; i >= 0; i--) pkt.push_back(dst[i*8 +: 8]);
        pkt.push_back(sp[15:8]); pkt.push_back(sp[7:0]);
        pkt.push_back(dp[15:8]); pkt.push_back(dp[7:0]);
        pkt.push_back(8'((plen + 8) >> 8)); pkt.push_back(8'(plen + 8));
        pkt.push_back(ucs[15:8]); pkt.push_back(ucs[7:0]);
        for (int i = 0; i < plen; i++) pkt.push_back(8'(seed * 13 + i * 7 + 1));
        sum = 0;
        for (int w = 0; w < 10; w++) sum += {pkt[2*w], pkt[2*w+1]};
        while (sum > 16'hFFFF) sum = (sum & 16'hFFFF) + (sum >> 16);
        cs = ~sum[15:0];
        if (corrupt) cs = cs ^ 16'h0101;
        pkt[10] = cs[15:8];
        pkt[11] = cs[7:0];
    endtask

    task automatic send(input bit pass, input string tag, input bit cfg_now,
                        input logic [31:0] nip, input logic [31:0] nmask);
        int total, nin, plen, nout, n0;
        exp_meta_t em;
        exp_beat_t eb;
        total = pkt.size();
        nin   = (total + B - 1) / B;
        plen  = total - 28;
        nout  = (plen + B - 1) / B;
        n0    = cyc + 1;
        if (pass) begin
            em.cyc  = n0;
            em.len  = 16'(plen);
            em.rest = {pkt[12], pkt[13], pkt[14], pkt[15], pkt[1][7:2], pkt[1][1:0],
                       pkt[20], pkt[21], pkt[22], pkt[23]};
            mq.push_back(em);
            mtag.push_back(tag);
            for (int k = 0; k < nout; k++) begin
                eb.cyc  = n0 + k + 1;
                eb.data = '0;
                eb.keep = '0;
                for (int j = 0; j < B; j++) begin
                    if (k * B + j < plen) begin
                        eb.data[j*8 +: 8] = pkt[28 + k * B + j];
                        eb.keep[j] = 1'b1;
                    end
                end
                eb.last = (k == nout - 1);
                pq.push_back(eb);
                ptag.push_back(tag);
            end
        end else begin
            drop_tag = tag;
        end
        for (int j = 0; j < nin; j++) begin
            in_valid = 1'b1;
            in_first = (j == 0);
            in_last  = (j == nin - 1);
            in_data  = '0;
            in_keep  = '0;
            for (int b = 0; b < B; b++) begin
                if (j * B + b < total) begin
                    in_data[b*8 +: 8] = pkt[j * B + b];
                    in_keep[b] = 1'b1;
                end
            end
            cfg_load = cfg_now && (j == 0);
            cfg_ip   = nip;
            cfg_mask = nmask;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
        in_keep  = '0;
        cfg_load = 1'b0;
    endtask

    task automatic load_cfg(input logic [31:0] ip, input logic [31:0] mask);
        cfg_load = 1'b1;
        cfg_ip   = ip;
        cfg_mask = mask;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic expect_quiet(input string tag, input int base);
        repeat (3) @(negedge clk);
        checks++;
        if (unexpected != base) begin
            errors++;
            $display("FAIL %s dropped packet: spurious outputs actual=%0d expected=0", tag, unexpected - base);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            while (mq.size() > 0 && mq[0].cyc < cyc) begin
                checks++; errors++;
                $display("FAIL %s R9 metadata missing at cycle %0d actual=none expected=record", mtag[0], mq[0].cyc);
                void'(mq.pop_front()); void'(mtag.pop_front());
            end
            while (pq.size() > 0 && pq[0].cyc < cyc) begin
                checks++; errors++;
                $display("FAIL %s R9 payload beat missing at cycle %0d actual=none expected=beat", ptag[0], pq[0].cyc);
                void'(pq.pop_front()); void'(ptag.pop_front());
            end
            if (meta_valid) begin
                if (mq.size() > 0 && mq[0].cyc == cyc) begin
                    checks++;
                    if (meta_len !== mq[0].len) begin
                        errors++;
                        $display("FAIL %s R4 meta_len actual=%0d expected=%0d", mtag[0], meta_len, mq[0].len);
                    end
                    checks++;
                    if ({meta_src_ip, meta_dscp, meta_ecn, meta_src_port, meta_dst_port} !== mq[0].rest) begin
                        errors++;
                        $display("FAIL %s R3 meta fields actual=%h expected=%h", mtag[0],
                                 {meta_src_ip, meta_dscp, meta_ecn, meta_src_port, meta_dst_port}, mq[0].rest);
                    end
                    void'(mq.pop_front()); void'(mtag.pop_front());
                end else begin
                    checks++; errors++; unexpected++;
                    $display("FAIL %s unexpected metadata actual=valid expected=none cycle %0d", drop_tag, cyc);
                end
            end
            if (out_valid) begin
                if (pq.size() > 0 && pq[0].cyc == cyc) begin
                    logic [DW-1:0] m;
                    m = '0;
                    for (int j = 0; j < B; j++) if (pq[0].keep[j]) m[j*8 +: 8] = 8'hFF;
                    checks++;
                    if ((out_data & m) !== pq[0].data) begin
                        errors++;
                        $display("FAIL %s R8 payload data actual=%h expected=%h", ptag[0], out_data & m, pq[0].data);
                    end
                    checks++;
                    if (out_keep !== pq[0].keep || out_last !== pq[0].last) begin
                        errors++;
                        $display("FAIL %s R10 keep/last actual=%h/%b expected=%h/%b", ptag[0],
                                 out_keep, out_last, pq[0].keep, pq[0].last);
                    end
                    void'(pq.pop_front()); void'(ptag.pop_front());
                end else begin
                    checks++; errors++; unexpected++;
                    $display("FAIL %s unexpected payload beat actual=valid expected=none cycle %0d", drop_tag, cyc);
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [31:0] IP_A   = 32'h0A00_0005;
    localparam logic [31:0] MASK24 = 32'hFFFF_FF00;
    localparam logic [31:0] IP_B   = 32'h0A01_0009;
    localparam logic [31:0] MASK16 = 32'hFFFF_0000;
    localparam logic [31:0] PEER   = 32'hC0A8_0102;

    initial begin
        int base;
        repeat (3) @(negedge clk);
        checks++;
        if (meta_valid !== 1'b0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b%b expected=00", meta_valid, out_valid);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1: not yet configured
        base = unexpected;
        build(PEER, IP_A, 16'd1000, 16'd2000, 6'd0, 2'd0, 40, 16'h0, 1'b0, 1);
        send(1'b0, "R1", 1'b0, '0, '0);
        expect_quiet("R1", base);

        load_cfg(IP_A, MASK24);

        // R9: payload fits wholly in first-beat residue
        build(PEER, IP_A, 16'h1234, 16'h4321, 6'd46, 2'd1, 4, 16'h0, 1'b0, 2);
        send(1'b1, "R9", 1'b0, '0, '0);
        repeat (2) @(negedge clk);

        // R8: long multi-beat payload with DSCP/ECN set (R3)
        build(PEER, IP_A, 16'hBEEF, 16'd53, 6'd10, 2'd3, 100, 16'h0, 1'b0, 3);
        send(1'b1, "R8", 1'b0, '0, '0);
        repeat (2) @(negedge clk);

        // R10: payload exactly one full beat, ends in lower lanes
        build(PEER, IP_A, 16'd7, 16'd9, 6'd0, 2'd2, 32, 16'h0, 1'b0, 4);
        send(1'b1, "R10", 1'b0, '0, '0);
        repeat (2) @(negedge clk);

        // R11: empty payload
        build(PEER, IP_A, 16'd5, 16'd6, 6'd1, 2'd0, 0, 16'h0, 1'b0, 5);
        send(1'b1, "R11", 1'b0, '0, '0);
        repeat (2) @(negedge clk);

        // R6: nonzero UDP checksum still accepted
        build(PEER, IP_A, 16'd11, 16'd12, 6'd0, 2'd0, 36, 16'hDEAD, 1'b0, 6);
        send(1'b1, "R6", 1'b0, '0, '0);
        repeat (2) @(negedge clk);

        // R5: corrupted header checksum
        base = unexpected;
        build(PEER, IP_A, 16'd11, 16'd12, 6'd0, 2'd0, 40, 16'h0, 1'b1, 7);
        send(1'b0, "R5", 1'b0, '0, '0);
        expect_quiet("R5", base);

        // R7: foreign destination dropped, subnet broadcast accepted
        base = unexpected;
        build(PEER, 32'h0A00_0006, 16'd1, 16'd2, 6'd0, 2'd0, 20, 16'h0, 1'b0, 8);
        send(1'b0, "R7", 1'b0, '0, '0);
        expect_quiet("R7", base);
        build(PEER, 32'h0A00_00FF, 16'd3, 16'd4, 6'd0, 2'd0, 50, 16'h0, 1'b0, 9);
        send(1'b1, "R7", 1'b0, '0, '0);
        repeat (2) @(negedge clk);

        // R12: back-to-back pass, fail, pass, each with flush beats
        base = unexpected;
        build(PEER, IP_A, 16'd21, 16'd22, 6'd3, 2'd1, 36, 16'h0, 1'b0, 10);
        send(1'b1, "R12", 1'b0, '0, '0);
        build(PEER, IP_A, 16'd23, 16'd24, 6'd0, 2'd0, 100, 16'h0, 1'b1, 11);
        send(1'b0, "R12", 1'b0, '0, '0);
        build(PEER, IP_A, 16'd25, 16'd26, 6'd5, 2'd2, 4, 16'h0, 1'b0, 12);
        send(1'b1, "R12", 1'b0, '0, '0);
        build(PEER, IP_A, 16'd27, 16'd28, 6'd0, 2'd0, 100, 16'h0, 1'b0, 13);
        send(1'b1, "R12", 1'b0, '0, '0);
        expect_quiet("R12", base);

        // R2: config load in the same cycle as a first beat applies later
        base = unexpected;
        build(PEER, IP_B, 16'd31, 16'd32, 6'd0, 2'd0, 24, 16'h0, 1'b0, 14);
        send(1'b0, "R2", 1'b1, IP_B, MASK16);
        expect_quiet("R2", base);
        build(PEER, IP_B, 16'd33, 16'd34, 6'd0, 2'd0, 24, 16'h0, 1'b0, 15);
        send(1'b1, "R2", 1'b0, '0, '0);
        repeat (4) @(negedge clk);

        checks++;
        if (mq.size() != 0 || pq.size() != 0) begin
            errors++;
            $display("FAIL R9 outstanding outputs actual=%0d/%0d expected=0/0", mq.size(), pq.size());
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule